// File: doc/BRIEF.md
# Bunch-Crossing Matched Capture Pulse Generator

This block decides when a set of event data memories records a snapshot. It watches a bunch-crossing number and a turn number that advance with the machine timing, one crossing per clock. When both equal targets loaded by control software, it raises a capture pulse for a programmable number of crossings. In monitoring mode the pulse is started instead by the rising edge of an external collect-status request, and crossing matches are ignored.

Alongside the pulse it produces an accept strobe. In local-timing mode the strobe is generated internally a programmed number of crossings after the pulse starts. In the two other modes the strobe is taken straight from an external accept input. An optional freeze flag rises when a capture ends and stays set until software writes an acknowledge, so that a readout always sees one whole event. Width and offset are written into shadow registers and loaded into the running counters only when the next trigger fires, so a pulse in progress is never changed.

All pins are plain control and status signals. There is no data stream, so no valid/ready handshake and no back-pressure.

Top module: `capture_pulse_gen`

## Requirements
- R1: While rst_n is low, and after its release until a trigger fires, cap_pulse, accept and freeze are all low.
- R2: In control modes 0 and 1, a trigger fires on the clock edge that ends the first cycle in which bx_num equals the target crossing (address 0) and turn_num equals the target turn (address 1). The match must not have been true in the cycle before. cap_pulse is high from the next cycle onward. A target write takes effect for the next comparison.
- R3: cap_pulse stays high for exactly W consecutive cycles, where W is the width written to address 2. A width of 0 gives 1 cycle, and a width above DEPTH gives DEPTH cycles.
- R4: A width or offset write is used only by the next trigger that fires after the write edge. A write made during a pulse does not change that pulse. A write in the same cycle as a trigger does not apply to that trigger.
- R5: In control mode 0, accept is high for one cycle, exactly O cycles after the first cycle of cap_pulse, where O is the offset written to address 3. This holds for any O up to 2^OFSW-1, including offsets far beyond the pulse width.
- R6: In control modes 1, 2 and 3, accept equals ext_accept in the same cycle, and no locally timed strobe appears.
- R7: In control modes 2 and 3, a trigger fires on the rising edge of collect_req, with the same pulse timing as R2 and R3. Crossing/turn matches and a request held high start nothing.
- R8: A trigger event is ignored while cap_pulse is high, or while a mode 0 accept countdown has not yet produced its strobe.
- R9: With freeze enabled (address 4, bit 2), freeze rises in the cycle after the last cycle of cap_pulse. It then stays high until an acknowledge (any write to address 5), and clears in the cycle after that write. Trigger events are ignored while freeze is high. An acknowledge made on the same edge that sets freeze is lost, and freeze is set.
- R10: With freeze disabled, no capture sets freeze.

Control register (address 4): bits [1:0] select the mode (0 local timing, 1 external accept, 2 and 3 monitoring), and bit 2 enables freeze. The control register takes effect at its write edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Crossing clock, one cycle per bunch crossing |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address (0 target crossing, 1 target turn, 2 width, 3 offset, 4 control, 5 acknowledge) |
| wr_data | input | DW | Register write data |
| bx_num | input | BXW | Current bunch-crossing number |
| turn_num | input | TURNW | Current turn number |
| collect_req | input | 1 | Collect-status request, used in monitoring mode |
| ext_accept | input | 1 | External accept strobe |
| cap_pulse | output | 1 | Capture pulse to the event memories |
| accept | output | 1 | Accept strobe |
| freeze | output | 1 | Memory write freeze flag |

## Verification
Two pairs of functions can fall in the same cycle. The first pair is a shadow write and the trigger it must not affect. The bench writes a new width in the very cycle that a crossing match is presented, and expects the old width for that pulse and the new width for the next one. The second pair is the freeze being set and an acknowledge write. The bench issues the acknowledge during the final pulse cycle, so that it lands on the edge that sets freeze, and expects freeze to stay high until a second acknowledge. A scoreboard compares every pulse's start cycle and length, and every accept cycle, with values worked out from the requirements. Any pulse that should have been ignored shows up as an unexpected item.

// File: rtl/cpg_pkg.sv
package cpg_pkg;

  typedef enum logic [1:0] {
    MODE_LOCAL   = 2'd0,
    MODE_EXTACC  = 2'd1,
    MODE_MONITOR = 2'd2,
    MODE_MONALT  = 2'd3
  } src_mode_e;

  localparam logic [2:0] A_TGT_BX   = 3'd0;
  localparam logic [2:0] A_TGT_TURN = 3'd1;
  localparam logic [2:0] A_WIDTH    = 3'd2;
  localparam logic [2:0] A_OFFSET   = 3'd3;
  localparam logic [2:0] A_CTRL     = 3'd4;
  localparam logic [2:0] A_ACK      = 3'd5;

  localparam int CTRL_FRZ_BIT = 2;

  function automatic logic mode_is_monitor(src_mode_e m);
    return m[1];
  endfunction

endpackage

// File: rtl/cpg_regs.sv
module cpg_regs
  import cpg_pkg::*;
#(
  parameter int DW    = 16,
  parameter int BXW   = 12,
  parameter int TURNW = 16,
  parameter int DEPTH = 64,
  parameter int OFSW  = 10,
  localparam int WW   = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [2:0]       wr_addr,
  input  logic [DW-1:0]    wr_data,
  output logic [BXW-1:0]   tgt_bx,
  output logic [TURNW-1:0] tgt_turn,
  output logic [WW-1:0]    ld_width,
  output logic [OFSW-1:0]  ld_ofs,
  output src_mode_e        mode,
  output logic             frz_en,
  output logic             ack_wr
);

  // Shadow width is kept at full write width so that oversize values clamp.
  logic [DW-1:0] sh_width;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tgt_bx   <= '0;
      tgt_turn <= '0;
      sh_width <= DW'(1);
      ld_ofs   <= '0;
      mode     <= MODE_LOCAL;
      frz_en   <= 1'b0;
    end else if (wr_en) begin
      unique case (wr_addr)
        A_TGT_BX:   tgt_bx   <= wr_data[BXW-1:0];
        A_TGT_TURN: tgt_turn <= wr_data[TURNW-1:0];
        A_WIDTH:    sh_width <= wr_data;
        A_OFFSET:   ld_ofs   <= wr_data[OFSW-1:0];
        A_CTRL: begin
          mode   <= src_mode_e'(wr_data[1:0]);
          frz_en <= wr_data[CTRL_FRZ_BIT];
        end
        default: ;
      endcase
    end
  end

  // Legal width range is 1..DEPTH.
  always_comb begin
    if (sh_width == '0) begin
      ld_width = WW'(1);
    end else if (sh_width > DW'(DEPTH)) begin
      ld_width = WW'(DEPTH);
    end else begin
      ld_width = sh_width[WW-1:0];
    end
  end

  assign ack_wr = wr_en && (wr_addr == A_ACK);

endmodule

// File: rtl/cpg_trigger.sv
module cpg_trigger #(
  parameter int BXW   = 12,
  parameter int TURNW = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [BXW-1:0]   bx_num,
  input  logic [TURNW-1:0] turn_num,
  input  logic             collect_req,
  input  logic             use_req,
  input  logic [BXW-1:0]   tgt_bx,
  input  logic [TURNW-1:0] tgt_turn,
  input  logic             busy,
  input  logic             frozen,
  output logic             fire
);

  logic match, match_q, req_q;
  logic match_edge, req_edge, src_event;

  assign match = (bx_num == tgt_bx) && (turn_num == tgt_turn);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      match_q <= 1'b0;
      req_q   <= 1'b0;
    end else begin
      match_q <= match;
      req_q   <= collect_req;
    end
  end

  assign match_edge = match & ~match_q;
  assign req_edge   = collect_req & ~req_q;
  assign src_event  = use_req ? req_edge : match_edge;
  assign fire       = src_event & ~busy & ~frozen;

endmodule

// File: rtl/cpg_timer.sv
module cpg_timer #(
  parameter int DEPTH = 64,
  parameter int OFSW  = 10,
  localparam int WW   = $clog2(DEPTH + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            fire,
  input  logic            gen_acc,
  input  logic [WW-1:0]   ld_width,
  input  logic [OFSW-1:0] ld_ofs,
  output logic            pulse,
  output logic            pulse_last,
  output logic            loc_acc,
  output logic            busy
);

  // These counters are the active parameter set: loaded from the shadows at fire.
  logic [WW-1:0] pcnt;
  logic [OFSW:0] acnt;
  logic [OFSW:0] ofs_plus;

  assign ofs_plus = {1'b0, ld_ofs} + {{OFSW{1'b0}}, 1'b1};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pcnt <= '0;
      acnt <= '0;
    end else if (fire) begin
      pcnt <= ld_width;
      acnt <= gen_acc ? ofs_plus : '0;
    end else begin
      if (pcnt != '0) pcnt <= pcnt - WW'(1);
      if (acnt != '0) acnt <= acnt - {{OFSW{1'b0}}, 1'b1};
    end
  end

  assign pulse      = (pcnt != '0);
  assign pulse_last = (pcnt == WW'(1));
  assign loc_acc    = (acnt == {{OFSW{1'b0}}, 1'b1});
  assign busy       = pulse | (acnt != '0);

endmodule

// File: rtl/cpg_freeze.sv
module cpg_freeze (
  input  logic clk,
  input  logic rst_n,
  input  logic frz_en,
  input  logic pulse_last,
  input  logic ack_wr,
  output logic frozen
);

  // Set has priority: an acknowledge cannot cancel a capture that ends on its edge.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      frozen <= 1'b0;
    end else if (frz_en && pulse_last) begin
      frozen <= 1'b1;
    end else if (ack_wr) begin
      frozen <= 1'b0;
    end
  end

endmodule

// File: rtl/capture_pulse_gen.sv
module capture_pulse_gen
  import cpg_pkg::*;
#(
  parameter int DW    = 16,
  parameter int BXW   = 12,
  parameter int TURNW = 16,
  parameter int DEPTH = 64,
  parameter int OFSW  = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [2:0]       wr_addr,
  input  logic [DW-1:0]    wr_data,
  input  logic [BXW-1:0]   bx_num,
  input  logic [TURNW-1:0] turn_num,
  input  logic             collect_req,
  input  logic             ext_accept,
  output logic             cap_pulse,
  output logic             accept,
  output logic             freeze
);

  localparam int WW = $clog2(DEPTH + 1);

  logic [BXW-1:0]   tgt_bx;
  logic [TURNW-1:0] tgt_turn;
  logic [WW-1:0]    ld_width;
  logic [OFSW-1:0]  ld_ofs;
  src_mode_e        mode;
  logic             frz_en, ack_wr;
  logic             fire, busy, frozen, pulse, pulse_last, loc_acc;
  logic             is_local, use_req;

  assign is_local = (mode == MODE_LOCAL);
  assign use_req  = mode_is_monitor(mode);

  cpg_regs #(
    .DW(DW), .BXW(BXW), .TURNW(TURNW), .DEPTH(DEPTH), .OFSW(OFSW)
  ) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data),
    .tgt_bx   (tgt_bx),
    .tgt_turn (tgt_turn),
    .ld_width (ld_width),
    .ld_ofs   (ld_ofs),
    .mode     (mode),
    .frz_en   (frz_en),
    .ack_wr   (ack_wr)
  );

  cpg_trigger #(
    .BXW(BXW), .TURNW(TURNW)
  ) u_trig (
    .clk         (clk),
    .rst_n       (rst_n),
    .bx_num      (bx_num),
    .turn_num    (turn_num),
    .collect_req (collect_req),
    .use_req     (use_req),
    .tgt_bx      (tgt_bx),
    .tgt_turn    (tgt_turn),
    .busy        (busy),
    .frozen      (frozen),
    .fire        (fire)
  );

  cpg_timer #(
    .DEPTH(DEPTH), .OFSW(OFSW)
  ) u_timer (
    .clk        (clk),
    .rst_n      (rst_n),
    .fire       (fire),
    .gen_acc    (is_local),
    .ld_width   (ld_width),
    .ld_ofs     (ld_ofs),
    .pulse      (pulse),
    .pulse_last (pulse_last),
    .loc_acc    (loc_acc),
    .busy       (busy)
  );

  cpg_freeze u_frz (
    .clk        (clk),
    .rst_n      (rst_n),
    .frz_en     (frz_en),
    .pulse_last (pulse_last),
    .ack_wr     (ack_wr),
    .frozen     (frozen)
  );

  assign cap_pulse = pulse;
  assign accept    = is_local ? loc_acc : ext_accept;
  assign freeze    = frozen;

endmodule

// File: rtl/cpg_checker.sv
module cpg_checker #(
  parameter int DEPTH = 64
) (
  input logic clk,
  input logic rst_n,
  input logic fire,
  input logic cap_pulse,
  input logic accept,
  input logic freeze,
  input logic ack_wr,
  input logic frz_en,
  input logic is_local
);

  localparam int LW = $clog2(DEPTH + 2);

  logic [LW-1:0] run_len;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run_len <= '0;
    end else if (cap_pulse) begin
      run_len <= run_len + LW'(1);
    end else begin
      run_len <= '0;
    end
  end

  p_fire_starts_r2: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> cap_pulse);

  p_width_cap_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cap_pulse |-> (run_len < LW'(DEPTH)));

  p_acc_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (is_local && accept) |=> !(is_local && accept));

  p_frozen_blocks_r8: assert property (@(posedge clk) disable iff (!rst_n)
    freeze |-> !fire);

  p_freeze_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (freeze && !ack_wr) |=> freeze);

  p_freeze_needs_en_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(freeze) |-> $past(frz_en));

endmodule

bind capture_pulse_gen cpg_checker #(.DEPTH(DEPTH)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .fire      (fire),
  .cap_pulse (cap_pulse),
  .accept    (accept),
  .freeze    (freeze),
  .ack_wr    (ack_wr),
  .frz_en    (frz_en),
  .is_local  (is_local)
);

// File: tb/sim_capture_pulse_gen.sv
`timescale 1ns/1ps
module sim_capture_pulse_gen;

  localparam int DW = 16, BXW = 12, TURNW = 16, DEPTH = 64, OFSW = 10;
  localparam int IDLE_BX = 4000;
  localparam int K_PULSE = 0, K_ACC = 1;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             wr_en = 1'b0;
  logic [2:0]       wr_addr = '0;
  logic [DW-1:0]    wr_data = '0;
  logic [BXW-1:0]   bx_num = BXW'(IDLE_BX);
  logic [TURNW-1:0] turn_num = '0;
  logic             collect_req = 1'b0;
  logic             ext_accept = 1'b0;
  logic             cap_pulse, accept, freeze;

  capture_pulse_gen u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .bx_num(bx_num), .turn_num(turn_num), .collect_req(collect_req),
    .ext_accept(ext_accept), .cap_pulse(cap_pulse), .accept(accept), .freeze(freeze)
  );

  always #4 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int total = 0;
  int bad = 0;

  typedef struct { int kind; int at; int val; } item_t;
  item_t exp_q[$];
  string tag_q[$];

  task automatic chk(input bit ok, input string tag, input int act, input int expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", tag, act, expv, cyc);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #2;
  endtask

  task automatic at_neg();
    @(negedge clk);
  endtask

  task automatic wait_n(input int n);
    repeat (n) tick();
  endtask

  task automatic wr(input logic [2:0] a, input int d);
    wr_en = 1'b1;
    wr_addr = a;
    wr_data = DW'(d);
    tick();
    wr_en = 1'b0;
  endtask

  task automatic push(input int kind, input int at, input int val, input string tag);
    item_t it;
    it.kind = kind;
    it.at = at;
    it.val = val;
    exp_q.push_back(it);
    tag_q.push_back(tag);
  endtask

  // Expectations for a pulse starting at s with width w and, when loc, an accept at s+o.
  task automatic expect_event(input int s, input int w, input int o, input bit loc);
    if (loc && o < w) push(K_ACC, s + o, 0, "R5");
    push(K_PULSE, s, w, "R2 R3");
    if (loc && o >= w) push(K_ACC, s + o, 0, "R5");
  endtask

  task automatic fire_match(input int bx, input int tn, input int w, input int o,
                            input bit loc, output int s);
    bx_num = BXW'(bx);
    turn_num = TURNW'(tn);
    s = cyc + 1;
    expect_event(s, w, o, loc);
    tick();
    bx_num = BXW'(IDLE_BX);
  endtask

  task automatic present_match(input int bx, input int tn);
    bx_num = BXW'(bx);
    turn_num = TURNW'(tn);
    tick();
    bx_num = BXW'(IDLE_BX);
  endtask

  // Scoreboard monitor.
  bit mon_en = 1'b0;
  bit prev_p = 1'b0;
  int start_obs = 0;

  task automatic observe(input int kind, input int at, input int val);
    item_t e;
    string t;
    if (exp_q.size() == 0) begin
      chk(1'b0, kind == K_PULSE ? "R8 unexpected pulse" : "R6 unexpected accept", at, -1);
    end else begin
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      chk(e.kind == kind, {t, " kind"}, kind, e.kind);
      chk(e.at == at, {t, " cycle"}, at, e.at);
      if (kind == K_PULSE) chk(e.val == val, {t, " width"}, val, e.val);
    end
  endtask

  always @(negedge clk) begin
    if (mon_en) begin
      if (cap_pulse && !prev_p) start_obs = cyc;
      if (!cap_pulse && prev_p) observe(K_PULSE, start_obs, cyc - start_obs);
      if (accept) observe(K_ACC, cyc, 0);
      prev_p = cap_pulse;
    end
  end

  initial begin
    #(8 * 150000);
    bad++;
    total++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int s;
    int s2;
    // R1 reset state
    repeat (3) at_neg();
    chk(cap_pulse == 1'b0, "R1 pulse in reset", int'(cap_pulse), 0);
    chk(accept == 1'b0, "R1 accept in reset", int'(accept), 0);
    chk(freeze == 1'b0, "R1 freeze in reset", int'(freeze), 0);
    tick();
    rst_n = 1'b1;
    wait_n(2);
    at_neg();
    chk(!cap_pulse && !accept && !freeze, "R1 after release", int'(cap_pulse), 0);
    mon_en = 1'b1;
    tick();

    // R2 R3 R5 basic local capture
    wr(cpg_pkg::A_CTRL, 0);
    wr(cpg_pkg::A_TGT_BX, 10);
    wr(cpg_pkg::A_TGT_TURN, 3);
    wr(cpg_pkg::A_WIDTH, 5);
    wr(cpg_pkg::A_OFFSET, 2);
    fire_match(10, 3, 5, 2, 1'b1, s);
    wait_n(12);
    at_neg();
    chk(freeze == 1'b0, "R10 freeze disabled", int'(freeze), 0);
    tick();

    // R3 clamps
    wr(cpg_pkg::A_WIDTH, 0);
    wr(cpg_pkg::A_OFFSET, 0);
    fire_match(10, 3, 1, 0, 1'b1, s);
    wait_n(5);
    wr(cpg_pkg::A_WIDTH, 100);
    wr(cpg_pkg::A_OFFSET, 3);
    fire_match(10, 3, DEPTH, 3, 1'b1, s);
    wait_n(DEPTH + 6);

    // R4 write during a pulse leaves it unchanged
    wr(cpg_pkg::A_WIDTH, 6);
    wr(cpg_pkg::A_OFFSET, 1);
    fire_match(10, 3, 6, 1, 1'b1, s);
    tick();
    wr(cpg_pkg::A_WIDTH, 9);
    wr(cpg_pkg::A_OFFSET, 4);
    wait_n(10);
    // R4 write in the same cycle as the trigger: old values used
    bx_num = BXW'(10);
    turn_num = TURNW'(3);
    s = cyc + 1;
    expect_event(s, 9, 4, 1'b1);
    wr(cpg_pkg::A_WIDTH, 3);
    bx_num = BXW'(IDLE_BX);
    wait_n(15);
    fire_match(10, 3, 3, 4, 1'b1, s);
    wait_n(8);
    // R2 new target takes over; old target no longer fires
    wr(cpg_pkg::A_TGT_BX, 20);
    present_match(10, 3);
    wait_n(5);
    fire_match(20, 3, 3, 4, 1'b1, s);
    wait_n(10);

    // R8 retrigger during pulse, and during accept countdown
    wr(cpg_pkg::A_WIDTH, 8);
    wr(cpg_pkg::A_OFFSET, 1);
    fire_match(20, 3, 8, 1, 1'b1, s);
    wait_n(2);
    present_match(20, 3);
    wait_n(12);
    wr(cpg_pkg::A_WIDTH, 2);
    wr(cpg_pkg::A_OFFSET, 20);
    fire_match(20, 3, 2, 20, 1'b1, s);
    wait_n(5);
    present_match(20, 3);
    wait_n(25);

    // R5 long offset well past the pulse
    wr(cpg_pkg::A_WIDTH, 4);
    wr(cpg_pkg::A_OFFSET, 300);
    fire_match(20, 3, 4, 300, 1'b1, s);
    wait_n(310);

    // R6 external accept mode
    wr(cpg_pkg::A_CTRL, 1);
    fire_match(20, 3, 4, 300, 1'b0, s);
    wait_n(8);
    ext_accept = 1'b1;
    push(K_ACC, cyc, 0, "R6");
    tick();
    ext_accept = 1'b0;
    wait_n(320);

    // R7 monitoring mode
    wr(cpg_pkg::A_CTRL, 2);
    present_match(20, 3);
    for (int i = 0; i < 4; i++) begin
      at_neg();
      chk(cap_pulse == 1'b0, "R7 match ignored", int'(cap_pulse), 0);
    end
    tick();
    collect_req = 1'b1;
    push(K_PULSE, cyc + 1, 4, "R7");
    wait_n(10);
    collect_req = 1'b0;
    wait_n(3);
    ext_accept = 1'b1;
    push(K_ACC, cyc, 0, "R6 R7");
    tick();
    ext_accept = 1'b0;
    wait_n(3);

    // R9 freeze after capture, blocking, acknowledge
    wr(cpg_pkg::A_CTRL, 4);
    wr(cpg_pkg::A_OFFSET, 0);
    fire_match(20, 3, 4, 0, 1'b1, s);
    while (cyc < s + 4) tick();
    at_neg();
    chk(freeze == 1'b1, "R9 freeze set after pulse", int'(freeze), 1);
    tick();
    present_match(20, 3);
    for (int i = 0; i < 4; i++) begin
      at_neg();
      chk(cap_pulse == 1'b0, "R9 trigger ignored while frozen", int'(cap_pulse), 0);
    end
    chk(freeze == 1'b1, "R9 freeze held", int'(freeze), 1);
    tick();
    wr(cpg_pkg::A_ACK, 0);
    at_neg();
    chk(freeze == 1'b0, "R9 ack clears", int'(freeze), 0);
    tick();
    // R9 ack on the same edge as set: set wins
    fire_match(20, 3, 4, 0, 1'b1, s2);
    while (cyc < s2 + 3) tick();
    wr(cpg_pkg::A_ACK, 0);
    at_neg();
    chk(freeze == 1'b1, "R9 set beats ack", int'(freeze), 1);
    tick();
    wait_n(2);
    at_neg();
    chk(freeze == 1'b1, "R9 still frozen", int'(freeze), 1);
    tick();
    wr(cpg_pkg::A_ACK, 0);
    at_neg();
    chk(freeze == 1'b0, "R9 second ack clears", int'(freeze), 0);
    tick();

    wait_n(10);
    chk(exp_q.size() == 0, "R2 missing expected items", exp_q.size(), 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule